// File: doc/BRIEF.md
# Set-Associative Translation Buffer Command Unit

This block holds the page descriptors of a set-associative translation buffer. The buffer has a parameterised number of sets and either 2 or 4 ways. Software never touches the entries directly. It loads an index register and two descriptor registers through a small write port, then issues a command. Each command runs in a fixed two-cycle sequence and ends with a done pulse. The commands are: search for a tag, choose a slot for a new tag, read an entry, store an entry, place a pair without a prior search, and remove matching entries.

The first descriptor holds the match key and validity. This is the virtual page number, an 8-bit address-space identifier and a present flag. The second descriptor carries the frame number and permissions, and the block stores it without interpreting it. Commands that change the entries in a way the small first-level translation caches must notice raise a one-cycle invalidate pulse toward them. A dedicated store variant leaves those caches untouched.

Top module: `jtlb_cmd_unit`

## Requirements
- R1: After reset every entry is absent, the index and both descriptor outputs read zero, and busy, done and the invalidate pulse are low.
- R2: The linear entry index is set × WAYS + way, so a set's ways are consecutive. The set of a key is taken from descriptor-0 bits [PAGE_SHIFT+6:PAGE_SHIFT] (default bits 19:13), with 128 sets.
- R3: A search compares descriptor-0 bits 31:PAGE_SHIFT and 7:0 against every way of the key's set, and only entries whose present flag (bit 8) is set can match. One match loads the index with its linear index. No match loads 0x8000_0000, and more than one match loads 0xC000_0000.
- R4: Choose-slot loads the index with the lowest-numbered absent way of the key's set. If all ways are present, it uses that set's rotating pointer, which then advances by one, modulo WAYS.
- R5: Store (code 4) writes both descriptors to the entry named by the index register and pulses the invalidate output in the done cycle. Store-quiet (code 5) writes the same way but never pulses.
- R6: Read (code 3) loads both descriptor registers from the entry named by the index register.
- R7: Insert (code 6) overwrites the lowest matching way of the key's set. With no match, it fills the way that choose-slot would pick and advances the pointer in the same way. The index register is unchanged, and the invalidate output pulses.
- R8: Remove (code 7) with present flag set in descriptor 0 zeroes every matching way of the key's set. With the flag clear it changes nothing. In both cases the invalidate output pulses.
- R9: Flush (code 8) only pulses the invalidate output.
- R10: A command write makes busy high for exactly the next cycle. The cycle after that shows done high for one cycle, with results visible. All register writes that arrive while busy is high are ignored.
- R11: Register select is 0 for index, 1 for descriptor 0, 2 for descriptor 1 and 3 for command, with the code in wdata[3:0]. Search is code 1 and choose-slot is code 2. Codes 0 and 9–15 complete with done and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| index_o | output | 32 | Index register |
| pd0_o | output | 32 | Descriptor 0 register |
| pd1_o | output | 32 | Descriptor 1 register |
| busy_o | output | 1 | Command executing |
| done_o | output | 1 | Command finished pulse |
| utlb_inv_o | output | 1 | First-level cache invalidate pulse |

## Verification
A corrupted entry or rotating pointer stays hidden until software asks about it. It surfaces at the index output in the done cycle of the next search or choose-slot on that set, or at the descriptor outputs after a read. The bench therefore follows each store with searches, reads and choose-slot commands on the same sets. These include full sets, so the pointer sequence is exposed. A wrong handshake or a missing or stray invalidate pulse shows within two cycles of the command write, because every output is compared against the model on every clock.

// File: rtl/jtlb_cmd_pkg.sv
package jtlb_cmd_pkg;

    typedef enum logic [3:0] {
        CMD_NOP        = 4'd0,
        CMD_PROBE      = 4'd1,
        CMD_GET_SLOT   = 4'd2,
        CMD_READ       = 4'd3,
        CMD_WRITE      = 4'd4,
        CMD_WRITE_KEEP = 4'd5,
        CMD_INSERT     = 4'd6,
        CMD_DELETE     = 4'd7,
        CMD_UFLUSH     = 4'd8
    } jtlb_cmd_e;

    localparam logic [1:0]  SEL_INDEX = 2'd0;
    localparam logic [1:0]  SEL_PD0   = 2'd1;
    localparam logic [1:0]  SEL_PD1   = 2'd2;
    localparam logic [1:0]  SEL_CMD   = 2'd3;

    localparam int          PRESENT_BIT = 8;
    localparam logic [31:0] IDX_MISS    = 32'h8000_0000;
    localparam logic [31:0] IDX_DUP     = 32'hC000_0000;

endpackage

// File: rtl/jtlb_way_match.sv
module jtlb_way_match #(
    parameter int          WAYS     = 4,
    parameter logic [31:0] TAG_MASK = 32'hFFFF_E0FF,
    localparam int         WB       = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][31:0] way_pd0,
    input  logic [31:0]           key,
    output logic [WAYS-1:0]       hit,
    output logic [WB-1:0]         hit_way,
    output logic                  multi_hit,
    output logic                  any_free,
    output logic [WB-1:0]         free_way
);
    import jtlb_cmd_pkg::*;

    always_comb begin
        hit      = '0;
        hit_way  = '0;
        any_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            hit[w] = way_pd0[w][PRESENT_BIT] &&
                     (((way_pd0[w] ^ key) & TAG_MASK) == 32'd0);
            if (hit[w]) begin
                hit_way = WB'(w);
            end
            if (!way_pd0[w][PRESENT_BIT]) begin
                free_way = WB'(w);
                any_free = 1'b1;
            end
        end
        multi_hit = ($countones(hit) > 1);
    end

endmodule

// File: rtl/jtlb_store.sv
module jtlb_store #(
    parameter int  SETS = 128,
    parameter int  WAYS = 4,
    localparam int SB   = $clog2(SETS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SB-1:0]         rd_set,
    output logic [WAYS-1:0][31:0] rd_pd0,
    output logic [WAYS-1:0][31:0] rd_pd1,
    input  logic [WAYS-1:0]       wr_mask,
    input  logic [SB-1:0]         wr_set,
    input  logic [31:0]           wr_pd0,
    input  logic [31:0]           wr_pd1
);
    logic [31:0] pd0_mem [WAYS][SETS];
    logic [31:0] pd1_mem [WAYS][SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) begin
                for (int s = 0; s < SETS; s++) begin
                    pd0_mem[w][s] <= '0;
                    pd1_mem[w][s] <= '0;
                end
            end
        end else begin
            for (int w = 0; w < WAYS; w++) begin
                if (wr_mask[w]) begin
                    pd0_mem[w][wr_set] <= wr_pd0;
                    pd1_mem[w][wr_set] <= wr_pd1;
                end
            end
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_pd0[w] = pd0_mem[w][rd_set];
            rd_pd1[w] = pd1_mem[w][rd_set];
        end
    end

endmodule

// File: rtl/jtlb_cmd_unit.sv
module jtlb_cmd_unit #(
    parameter int  SETS       = 128,
    parameter int  WAYS       = 4,
    parameter int  PAGE_SHIFT = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] index_o,
    output logic [31:0] pd0_o,
    output logic [31:0] pd1_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        utlb_inv_o
);
    import jtlb_cmd_pkg::*;

    localparam int          SB       = $clog2(SETS);
    localparam int          WB       = $clog2(WAYS);
    localparam int          EB       = SB + WB;
    localparam int          NE       = SETS * WAYS;
    localparam logic [31:0] TAG_MASK = ({32{1'b1}} << PAGE_SHIFT) | 32'h0000_00FF;

    typedef struct packed {
        logic                   busy;
        logic                   done;
        logic                   utlb;
        jtlb_cmd_e              cmd;
        logic [31:0]            idx;
        logic [31:0]            pd0;
        logic [31:0]            pd1;
        logic [SETS-1:0][WB-1:0] rr;
    } state_t;

    state_t st_q, st_d;

    logic [SB-1:0]         key_set, idx_set, rd_set, wr_set;
    logic [WB-1:0]         idx_way, hit_way, free_way, victim;
    logic [WAYS-1:0][31:0] rd_pd0, rd_pd1;
    logic [WAYS-1:0]       hit, wr_mask;
    logic                  multi_hit, any_free;
    logic [31:0]           wr_pd0, wr_pd1;

    assign key_set = st_q.pd0[PAGE_SHIFT +: SB];
    assign idx_set = st_q.idx[WB +: SB];
    assign idx_way = st_q.idx[WB-1:0];
    assign rd_set  = (st_q.cmd == CMD_READ) ? idx_set : key_set;
    assign victim  = any_free ? free_way : st_q.rr[key_set];

    jtlb_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_set  (rd_set),
        .rd_pd0  (rd_pd0),
        .rd_pd1  (rd_pd1),
        .wr_mask (wr_mask),
        .wr_set  (wr_set),
        .wr_pd0  (wr_pd0),
        .wr_pd1  (wr_pd1)
    );

    jtlb_way_match #(.WAYS(WAYS), .TAG_MASK(TAG_MASK)) u_match (
        .way_pd0   (rd_pd0),
        .key       (st_q.pd0),
        .hit       (hit),
        .hit_way   (hit_way),
        .multi_hit (multi_hit),
        .any_free  (any_free),
        .free_way  (free_way)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.utlb = 1'b0;
        wr_mask   = '0;
        wr_set    = key_set;
        wr_pd0    = st_q.pd0;
        wr_pd1    = st_q.pd1;
        if (st_q.busy) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            case (st_q.cmd)
                CMD_PROBE: begin
                    if (hit == '0)     st_d.idx = IDX_MISS;
                    else if (multi_hit) st_d.idx = IDX_DUP;
                    else               st_d.idx = {{(32-EB){1'b0}}, key_set, hit_way};
                end
                CMD_GET_SLOT: begin
                    st_d.idx = {{(32-EB){1'b0}}, key_set, victim};
                    if (!any_free) st_d.rr[key_set] = st_q.rr[key_set] + 1'b1;
                end
                CMD_READ: begin
                    st_d.pd0 = rd_pd0[idx_way];
                    st_d.pd1 = rd_pd1[idx_way];
                end
                CMD_WRITE, CMD_WRITE_KEEP: begin
                    wr_set           = idx_set;
                    wr_mask[idx_way] = 1'b1;
                    st_d.utlb        = (st_q.cmd == CMD_WRITE);
                end
                CMD_INSERT: begin
                    if (hit != '0) begin
                        wr_mask[hit_way] = 1'b1;
                    end else begin
                        wr_mask[victim] = 1'b1;
                        if (!any_free) st_d.rr[key_set] = st_q.rr[key_set] + 1'b1;
                    end
                    st_d.utlb = 1'b1;
                end
                CMD_DELETE: begin
                    if (st_q.pd0[PRESENT_BIT]) begin
                        wr_mask = hit;
                        wr_pd0  = '0;
                        wr_pd1  = '0;
                    end
                    st_d.utlb = 1'b1;
                end
                CMD_UFLUSH: st_d.utlb = 1'b1;
                default: ;
            endcase
        end else if (reg_we) begin
            case (reg_sel)
                SEL_INDEX: st_d.idx = reg_wdata;
                SEL_PD0:   st_d.pd0 = reg_wdata;
                SEL_PD1:   st_d.pd1 = reg_wdata;
                default: begin
                    st_d.busy = 1'b1;
                    st_d.cmd  = jtlb_cmd_e'(reg_wdata[3:0]);
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign index_o    = st_q.idx;
    assign pd0_o      = st_q.pd0;
    assign pd1_o      = st_q.pd1;
    assign busy_o     = st_q.busy;
    assign done_o     = st_q.done;
    assign utlb_inv_o = st_q.utlb;

    p_busy_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> (!st_q.busy && st_q.done));

    p_done_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> $past(st_q.busy));

    p_busy_blocks_pd1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cmd != CMD_READ) |=> $stable(st_q.pd1));

    p_flush_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.utlb |-> st_q.done);

    p_quiet_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cmd == CMD_WRITE_KEEP) |=> !st_q.utlb);

    p_probe_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && st_q.cmd == CMD_PROBE && !st_q.idx[31]) |-> (st_q.idx < NE));

endmodule

// File: tb/jtlb_cmd_unit_test.sv
module jtlb_cmd_unit_test;
    localparam int S  = 128;
    localparam int W  = 4;
    localparam int NE = S * W;
    localparam int unsigned TMASK = 32'hFFFF_E0FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] index_o, pd0_o, pd1_o;
    logic        busy_o, done_o, utlb_inv_o;

    int n_chk = 0;
    int n_fail = 0;
    bit armed = 1'b0;

    jtlb_cmd_unit #(.SETS(S), .WAYS(W), .PAGE_SHIFT(13)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .index_o(index_o), .pd0_o(pd0_o), .pd1_o(pd1_o),
        .busy_o(busy_o), .done_o(done_o), .utlb_inv_o(utlb_inv_o)
    );

    always #10 clk = ~clk;

    // behavioural reference model
    int unsigned mp0 [NE];
    int unsigned mp1 [NE];
    int          rrm [S];
    int unsigned m_idx = 0, m_pd0 = 0, m_pd1 = 0;
    bit          m_busy = 0, m_done = 0, m_utlb = 0;
    int          m_cmd = 0;

    task automatic m_exec();
        int set, base, nhit, first_hit, vic;
        bit full;
        set = int'((m_pd0 >> 13) & 127);
        base = set * W;
        nhit = 0; first_hit = -1; vic = -1;
        for (int w = 0; w < W; w++) begin
            if ((mp0[base+w] & 32'h100) != 0 && ((mp0[base+w] ^ m_pd0) & TMASK) == 0) begin
                nhit++;
                if (first_hit < 0) first_hit = w;
            end
            if ((mp0[base+w] & 32'h100) == 0 && vic < 0) vic = w;
        end
        full = (vic < 0);
        if (full) vic = rrm[set];
        case (m_cmd)
            1: m_idx = (nhit == 0) ? 32'h8000_0000 : (nhit > 1) ? 32'hC000_0000 : base + first_hit;
            2: begin m_idx = base + vic; if (full) rrm[set] = (rrm[set] + 1) % W; end
            3: begin m_pd0 = mp0[m_idx % NE]; m_pd1 = mp1[m_idx % NE]; end
            4, 5: begin mp0[m_idx % NE] = m_pd0; mp1[m_idx % NE] = m_pd1; m_utlb = (m_cmd == 4); end
            6: begin
                if (nhit > 0) vic = first_hit;
                else if (full) rrm[set] = (rrm[set] + 1) % W;
                mp0[base+vic] = m_pd0; mp1[base+vic] = m_pd1; m_utlb = 1;
            end
            7: begin
                if ((m_pd0 & 32'h100) != 0)
                    for (int w = 0; w < W; w++)
                        if ((mp0[base+w] & 32'h100) != 0 && ((mp0[base+w] ^ m_pd0) & TMASK) == 0) begin
                            mp0[base+w] = 0; mp1[base+w] = 0;
                        end
                m_utlb = 1;
            end
            8: m_utlb = 1;
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NE; e++) begin mp0[e] = 0; mp1[e] = 0; end
            for (int s = 0; s < S; s++) rrm[s] = 0;
            m_idx = 0; m_pd0 = 0; m_pd1 = 0; m_busy = 0; m_done = 0; m_utlb = 0; m_cmd = 0;
        end else begin
            m_done = 0; m_utlb = 0;
            if (m_busy) begin
                m_busy = 0; m_done = 1; m_exec();
            end else if (reg_we) begin
                case (reg_sel)
                    2'd0: m_idx = reg_wdata;
                    2'd1: m_pd0 = reg_wdata;
                    2'd2: m_pd1 = reg_wdata;
                    default: begin m_busy = 1; m_cmd = int'(reg_wdata[3:0]); end
                endcase
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (armed) begin
            chk("R3 index", index_o, m_idx);
            chk("R6 pd0", pd0_o, m_pd0);
            chk("R6 pd1", pd1_o, m_pd1);
            chk("R10 busy", {31'd0, busy_o}, {31'd0, m_busy});
            chk("R10 done", {31'd0, done_o}, {31'd0, m_done});
            chk("R5 invalidate", {31'd0, utlb_inv_o}, {31'd0, m_utlb});
        end
    end

    task automatic put(logic [1:0] s, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    bit last_inv;
    task automatic run(logic [3:0] c);
        put(2'd3, {28'd0, c});
        @(negedge clk);
        chk("R10 busy after command", {31'd0, busy_o}, 32'd1);
        @(negedge clk);
        chk("R10 done pulse", {31'd0, done_o}, 32'd1);
        last_inv = utlb_inv_o;
    endtask

    task automatic probe(logic [31:0] key, logic [31:0] exp, string tag);
        put(2'd1, key);
        run(4'd1);
        chk(tag, index_o, exp);
    endtask

    task automatic store(logic [31:0] idx, logic [31:0] p0, logic [31:0] p1, logic [3:0] c);
        put(2'd0, idx); put(2'd1, p0); put(2'd2, p1);
        run(c);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk);
        armed = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 index reset", index_o, 32'd0);
        chk("R1 pd0 reset", pd0_o, 32'd0);
        chk("R1 busy/done/inv low", {29'd0, busy_o, done_o, utlb_inv_o}, 32'd0);
        probe(32'h0000_0100, 32'h8000_0000, "R1 entries absent after reset");

        // R5 store with pulse; R2 linear index set5 way1 = 21
        store(32'd21, 32'h0000_A12A, 32'h1234_5007, 4'd4);
        chk("R5 store pulses invalidate", {31'd0, last_inv}, 32'd1);
        probe(32'h0000_A12A, 32'd21, "R2 R3 single hit index");
        probe(32'h0000_BB2A, 32'd21, "R3 offset bits 12:9 ignored");
        probe(32'h0000_A12B, 32'h8000_0000, "R3 other identifier misses");
        probe(32'h0010_A12A, 32'h8000_0000, "R2 page bits above set are tag");

        // R6 read back
        put(2'd1, 32'd0); put(2'd2, 32'd0); put(2'd0, 32'd21);
        run(4'd3);
        chk("R6 read pd0", pd0_o, 32'h0000_A12A);
        chk("R6 read pd1", pd1_o, 32'h1234_5007);

        // R5 quiet store creates a duplicate
        store(32'd22, 32'h0000_A12A, 32'h0000_0001, 4'd5);
        chk("R5 quiet store no pulse", {31'd0, last_inv}, 32'd0);
        probe(32'h0000_A12A, 32'hC000_0000, "R3 duplicate code");

        // R3 present flag clear never matches
        store(32'd40, 32'h0001_4005, 32'h0000_0002, 4'd4);
        probe(32'h0001_4105, 32'h8000_0000, "R3 absent entry misses");

        // R4 first free way of set 5 is way 0
        put(2'd1, 32'h0000_A12A);
        run(4'd2);
        chk("R4 first free slot", index_o, 32'd20);

        // R7 fill set 7 by insert
        for (int n = 0; n < 4; n++) begin
            put(2'd0, 32'd5);
            put(2'd1, 32'h0000_E111 | (n << 20)); put(2'd2, n);
            run(4'd6);
            chk("R7 insert keeps index, pulses", {index_o[30:0], last_inv}, {31'd5, 1'b1});
        end
        probe(32'h0020_E111, 32'd30, "R7 insert into free way");
        put(2'd1, 32'h0000_E111);
        run(4'd2);
        chk("R4 full set pointer first", index_o, 32'd28);
        run(4'd2);
        chk("R4 full set pointer advances", index_o, 32'd29);
        put(2'd1, 32'h0040_E111); put(2'd2, 32'h44);
        run(4'd6);
        probe(32'h0040_E111, 32'd30, "R7 insert uses pointer victim");
        probe(32'h0020_E111, 32'h8000_0000, "R7 victim replaced");
        put(2'd1, 32'h0010_E111); put(2'd2, 32'h99);
        run(4'd6);
        put(2'd0, 32'd29);
        run(4'd3);
        chk("R7 insert overwrites match", pd1_o, 32'h99);

        // R10 writes during busy are ignored
        put(2'd1, 32'h0000_A12A);
        put(2'd3, 32'd1);
        put(2'd1, 32'h0000_0777);
        @(negedge clk);
        chk("R10 write while busy ignored", pd0_o, 32'h0000_A12A);

        // R8 remove
        put(2'd1, 32'h0000_A02A);
        run(4'd7);
        chk("R8 remove pulses", {31'd0, last_inv}, 32'd1);
        probe(32'h0000_A12A, 32'hC000_0000, "R8 remove without present ignored");
        run(4'd7);
        probe(32'h0000_A12A, 32'h8000_0000, "R8 remove clears all matches");
        put(2'd0, 32'd22);
        run(4'd3);
        chk("R8 removed entry zero", pd0_o | pd1_o, 32'd0);

        // R9 flush, R11 unknown code
        run(4'd8);
        chk("R9 flush pulses", {31'd0, last_inv}, 32'd1);
        put(2'd1, 32'h0040_E111);
        run(4'hF);
        chk("R11 unknown code no pulse", {31'd0, last_inv}, 32'd0);
        probe(32'h0040_E111, 32'd30, "R11 unknown code changes nothing");

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule